// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

The bridge sits between one bus master and its memory port and gives every bit of two target regions a word-sized alias address of its own. Reading an alias word returns the addressed bit as 0 or 1. Writing an alias word sets or clears that bit in memory through a locked read-modify-write, so the master changes one bit with a single store and never disturbs its neighbours. Any request outside the alias windows is forwarded unchanged.

Each alias window covers 32 MiB. The target byte address is the window's target base ORed with the window offset shifted right by five. Byte, halfword and word alias accesses pick the bit from a progressively wider field of the offset. Upstream requests use a valid/ready handshake: the master holds its request until `up_ready` is high for one cycle, and read data is valid in that cycle. Downstream, the bridge issues one request at a time and holds it until memory acknowledges it.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_req`, `mem_lock` and `up_ready` are all low, and no memory access is issued until a request arrives.
- R2: An address in the alias window at 0x22000000..0x23FFFFFF maps to target 0x20000000 | (offset[24:0] >> 5), and one in 0x42000000..0x43FFFFFF maps to 0x40000000 | (offset[24:0] >> 5). The first address past each window is not an alias.
- R3: The bit index is offset[4:2] for `up_size`=0 (byte), offset[5:2] for `up_size`=1 (halfword) and offset[6:2] for `up_size`=2 (word). The target address has bit 0 cleared for a halfword and bits 1:0 cleared for a word, and the memory access uses the request's size.
- R4: An alias read returns 1 in `up_rdata` bit 0 when the selected bit of the target unit is set and 0 otherwise, with bits 31:1 all zero.
- R5: An alias write first issues a memory read of the target unit, then a memory write to the same address with the same size, and nothing else.
- R6: An alias write uses only bit 0 of `up_wdata`: 1 sets the selected bit, 0 clears it, and every other bit of the target unit is written back unchanged.
- R7: Memory data is little-endian on a 32-bit bus: byte lane n carries address offset n. Alias byte enables are 1 << addr[1:0] for a byte, 4'b0011 or 4'b1100 (by addr[1]) for a halfword and 4'b1111 for a word; bit k of a halfword or word is data bit k counted from its lowest-addressed byte.
- R8: `mem_lock` is high throughout both memory phases of an alias write, and `up_ready` stays low until the write phase has been acknowledged.
- R9: A request outside both windows reaches memory as one access with the original address, size, byte enables and write data; a read returns `mem_rdata` unchanged.
- R10: `mem_req` and its address stay stable until `mem_ack`; `up_ready` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Master request valid, held until accepted |
| up_ready | output | 1 | Request complete; read data valid |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Byte address |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_wdata | input | 32 | Write data |
| up_be | input | 4 | Byte enables for forwarded accesses |
| up_rdata | output | 32 | Read result |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_write | output | 1 | Memory access is a write |
| mem_lock | output | 1 | Locked read-modify-write in progress |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Memory access size |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The bench builds the bridge with its default parameters: 32-bit addresses, 25-bit window spans and the two windows at their standard bases. With these values the last alias word of the upper window (0x43FFFFFC) and the addresses just outside both windows (0x21FFFFFC, 0x44000000) fall on real window edges, so the decode boundaries, the word-aligned target of a top-of-window alias and the pass-through of near misses are exercised at their actual addresses. Halfword aliases into both halves of a word and byte aliases into an odd lane exercise the lane and alignment rules.

// File: rtl/bb_pkg.sv
package bb_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } bb_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_MODWR = 2'd2,
      ST_RESP  = 2'd3
   } bb_state_e;
endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode #(
   parameter int ADDR_W    = 32,
   parameter int SPAN_LOG2 = 25,
   parameter int NUM_WIN   = 2,
   parameter int SHIFT     = 5,
   parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES  = '0,
   parameter logic [NUM_WIN*ADDR_W-1:0] TARGET_BASES = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] target_o
);
   localparam int TAG_W = ADDR_W - SPAN_LOG2;

   logic [NUM_WIN-1:0] hit_w;
   logic [ADDR_W-1:0]  tgt_w [NUM_WIN];
   logic [ADDR_W-1:0]  off_ext;

   assign off_ext = ADDR_W'(addr_i[SPAN_LOG2-1:0]);

   for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
      assign hit_w[gi] = (addr_i[ADDR_W-1:SPAN_LOG2] ==
                          ALIAS_BASES[gi*ADDR_W+SPAN_LOG2 +: TAG_W]);
      assign tgt_w[gi] = TARGET_BASES[gi*ADDR_W +: ADDR_W] | (off_ext >> SHIFT);
   end

   // lowest-numbered window wins if bases ever overlap
   always_comb begin
      hit_o    = 1'b0;
      target_o = addr_i;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_w[i]) begin
            hit_o    = 1'b1;
            target_o = tgt_w[i];
         end
      end
   end
endmodule

// File: rtl/bb_bit_locate.sv
module bb_bit_locate
   import bb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0]          tgt_i,
   input  logic [4:0]                 sel_i,   // alias offset bits [6:2]
   input  logic [1:0]                 size_i,
   output logic [ADDR_W-1:0]          addr_o,
   output logic [$clog2(DATA_W)-1:0]  pos_o,
   output logic [DATA_W/8-1:0]        be_o
);
   localparam int LANES = DATA_W / 8;
   localparam int POS_W = $clog2(DATA_W);

   always_comb begin
      case (bb_size_e'(size_i))
         SZ_BYTE: begin
            addr_o = tgt_i;
            pos_o  = POS_W'({tgt_i[1:0], 3'b000}) + POS_W'(sel_i[2:0]);
            be_o   = LANES'(1) << tgt_i[1:0];
         end
         SZ_HALF: begin
            addr_o = {tgt_i[ADDR_W-1:1], 1'b0};
            pos_o  = POS_W'({tgt_i[1], 4'b0000}) + POS_W'(sel_i[3:0]);
            be_o   = tgt_i[1] ? LANES'(4'b1100) : LANES'(4'b0011);
         end
         default: begin
            addr_o = {tgt_i[ADDR_W-1:2], 2'b00};
            pos_o  = POS_W'(sel_i);
            be_o   = {LANES{1'b1}};
         end
      endcase
   end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]          rdata_i,
   input  logic [$clog2(DATA_W)-1:0]  pos_i,
   input  logic                       set_i,
   output logic                       bit_o,
   output logic [DATA_W-1:0]          merged_o
);
   logic [DATA_W-1:0] mask;

   assign mask     = DATA_W'(1) << pos_i;
   assign bit_o    = |(rdata_i & mask);
   assign merged_o = set_i ? (rdata_i | mask) : (rdata_i & ~mask);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
   import bb_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int SPAN_LOG2 = 25,
   parameter int NUM_WIN   = 2,
   parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
   parameter logic [NUM_WIN*ADDR_W-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic              up_write,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [1:0]        up_size,
   input  logic [DATA_W-1:0] up_wdata,
   input  logic [DATA_W/8-1:0] up_be,
   output logic [DATA_W-1:0] up_rdata,
   output logic              mem_req,
   input  logic              mem_ack,
   output logic              mem_write,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int LANES = DATA_W / 8;
   localparam int POS_W = $clog2(DATA_W);
   localparam int SHIFT = $clog2(DATA_W);   // one alias word per target bit

   if (DATA_W != 32) begin : g_bad_data_w
      $error("bitband_bridge: DATA_W must be 32");
   end
   if (SPAN_LOG2 < SHIFT + 2 || SPAN_LOG2 >= ADDR_W) begin : g_bad_span
      $error("bitband_bridge: SPAN_LOG2 out of range");
   end
   if (NUM_WIN < 1) begin : g_bad_win
      $error("bitband_bridge: NUM_WIN must be at least 1");
   end

   // ---------------- request decode ----------------
   logic              hit;
   logic [ADDR_W-1:0] tgt;
   logic [ADDR_W-1:0] al_addr;
   logic [POS_W-1:0]  al_pos;
   logic [LANES-1:0]  al_be;

   bb_window_decode #(
      .ADDR_W      (ADDR_W),
      .SPAN_LOG2   (SPAN_LOG2),
      .NUM_WIN     (NUM_WIN),
      .SHIFT       (SHIFT),
      .ALIAS_BASES (ALIAS_BASES),
      .TARGET_BASES(TARGET_BASES)
   ) u_decode (
      .addr_i  (up_addr),
      .hit_o   (hit),
      .target_o(tgt)
   );

   bb_bit_locate #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_locate (
      .tgt_i (tgt),
      .sel_i (up_addr[6:2]),
      .size_i(up_size),
      .addr_o(al_addr),
      .pos_o (al_pos),
      .be_o  (al_be)
   );

   // ---------------- latched request ----------------
   bb_state_e         state_q;
   logic              alias_q;
   logic              write_q;
   logic              setv_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        size_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] wdata_q;
   logic [POS_W-1:0]  pos_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] mod_q;

   logic              rd_bit;
   logic [DATA_W-1:0] merged;

   bb_bit_merge #(
      .DATA_W(DATA_W)
   ) u_merge (
      .rdata_i (mem_rdata),
      .pos_i   (pos_q),
      .set_i   (setv_q),
      .bit_o   (rd_bit),
      .merged_o(merged)
   );

   logic accept;
   assign accept = (state_q == ST_IDLE) && up_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alias_q <= 1'b0;
         write_q <= 1'b0;
         setv_q  <= 1'b0;
         addr_q  <= '0;
         size_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
         pos_q   <= '0;
      end else if (accept) begin
         alias_q <= hit;
         write_q <= up_write;
         setv_q  <= up_wdata[0];
         addr_q  <= hit ? al_addr : up_addr;
         size_q  <= up_size;
         be_q    <= hit ? al_be : up_be;
         wdata_q <= up_wdata;
         pos_q   <= al_pos;
      end
   end

   // ---------------- sequencer ----------------
   bb_state_e state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (up_valid) state_d = ST_READ;
         ST_READ:  if (mem_ack)  state_d = (alias_q && write_q) ? ST_MODWR : ST_RESP;
         ST_MODWR: if (mem_ack)  state_d = ST_RESP;
         ST_RESP:  if (up_valid) state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rdata_q <= '0;
         mod_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_READ && mem_ack) begin
            mod_q <= merged;
            if (write_q)      rdata_q <= '0;
            else if (alias_q) rdata_q <= DATA_W'(rd_bit);
            else              rdata_q <= mem_rdata;
         end
      end
   end

   // ---------------- port drive ----------------
   logic in_mem;
   assign in_mem    = (state_q == ST_READ) || (state_q == ST_MODWR);

   assign mem_req   = in_mem;
   assign mem_write = (state_q == ST_MODWR) || ((state_q == ST_READ) && !alias_q && write_q);
   assign mem_lock  = in_mem && alias_q && write_q;
   assign mem_addr  = addr_q;
   assign mem_size  = size_q;
   assign mem_be    = be_q;
   assign mem_wdata = (state_q == ST_MODWR) ? mod_q : wdata_q;

   assign up_ready  = (state_q == ST_RESP);
   assign up_rdata  = rdata_q;
endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int SPAN_LOG2 = 25,
   parameter int NUM_WIN   = 2,
   parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_valid,
   input logic              up_ready,
   input logic              up_write,
   input logic [ADDR_W-1:0] up_addr,
   input logic [DATA_W-1:0] up_rdata,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_write,
   input logic              mem_lock,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_size,
   input logic [DATA_W/8-1:0] mem_be
);
   localparam int TAG_W = ADDR_W - SPAN_LOG2;

   logic up_hit;
   always_comb begin
      up_hit = 1'b0;
      for (int i = 0; i < NUM_WIN; i++)
         if (up_addr[ADDR_W-1:SPAN_LOG2] == ALIAS_BASES[i*ADDR_W+SPAN_LOG2 +: TAG_W])
            up_hit = 1'b1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!mem_req && !mem_lock && !up_ready)); // R1

   AST_ALIAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready && !up_write && up_hit) |-> (up_rdata[DATA_W-1:1] == '0)); // R4

   AST_RMW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_lock && !mem_write && mem_ack) |=>
      (mem_req && mem_write && mem_lock && $stable(mem_addr) && $stable(mem_size))); // R5

   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_lock && mem_size == 2'd0) |-> ($countones(mem_be) == 1)); // R7

   AST_LOCK_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock |-> !up_ready); // R8

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write))); // R10

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (up_ready && up_valid) |=> !up_ready); // R10
endmodule

bind bitband_bridge bb_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .SPAN_LOG2  (SPAN_LOG2),
   .NUM_WIN    (NUM_WIN),
   .ALIAS_BASES(ALIAS_BASES)
) u_bb_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .up_valid (up_valid),
   .up_ready (up_ready),
   .up_write (up_write),
   .up_addr  (up_addr),
   .up_rdata (up_rdata),
   .mem_req  (mem_req),
   .mem_ack  (mem_ack),
   .mem_write(mem_write),
   .mem_lock (mem_lock),
   .mem_addr (mem_addr),
   .mem_size (mem_size),
   .mem_be   (mem_be)
);

// File: tb/bitband_bridge_bench.sv
module bitband_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic        up_write = 1'b0;
   logic [31:0] up_addr = '0;
   logic [1:0]  up_size = '0;
   logic [31:0] up_wdata = '0;
   logic [3:0]  up_be = '0;
   logic [31:0] up_rdata;
   logic        mem_req;
   logic        mem_ack;
   logic        mem_write;
   logic        mem_lock;
   logic [31:0] mem_addr;
   logic [1:0]  mem_size;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;

   always #4 clk = ~clk;   // 125 MHz

   bitband_bridge u_bitband_bridge (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
      .up_addr(up_addr), .up_size(up_size), .up_wdata(up_wdata),
      .up_be(up_be), .up_rdata(up_rdata),
      .mem_req(mem_req), .mem_ack(mem_ack), .mem_write(mem_write),
      .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // ---------------- memory model ----------------
   logic [31:0] words [logic [31:0]];
   logic        ack_q = 1'b0;
   logic [31:0] rd_q = '0;
   int          log_n = 0;
   logic        log_wr   [4];
   logic        log_lock [4];
   logic [31:0] log_addr [4];
   logic [1:0]  log_size [4];
   logic [3:0]  log_be   [4];
   logic [31:0] log_wd   [4];

   assign mem_ack   = ack_q;
   assign mem_rdata = rd_q;

   function automatic logic [31:0] peek(input logic [31:0] a);
      return words.exists(a >> 2) ? words[a >> 2] : 32'h0;
   endfunction

   always @(posedge clk) begin
      if (mem_req && !ack_q) begin
         logic [31:0] cur;
         cur = peek(mem_addr);
         if (mem_write) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) cur[8*b +: 8] = mem_wdata[8*b +: 8];
            words[mem_addr >> 2] = cur;
         end
         rd_q  <= cur;
         ack_q <= 1'b1;
         if (log_n < 4) begin
            log_wr[log_n]   = mem_write;
            log_lock[log_n] = mem_lock;
            log_addr[log_n] = mem_addr;
            log_size[log_n] = mem_size;
            log_be[log_n]   = mem_be;
            log_wd[log_n]   = mem_wdata;
         end
         log_n = log_n + 1;
      end else begin
         ack_q <= 1'b0;
      end
   end

   // ---------------- checking ----------------
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [3:0]  be;
      logic [31:0] exp_rd;
      logic [31:0] exp_maddr;
      logic [3:0]  exp_mbe;
      logic        is_alias;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t TBL [NV] = '{
      // word aliases into 0x20000000 (= 0x80000001)               R2 R3 R4
      '{1'b0, 2'd2, 32'h2200_0000, 32'h0, 4'hF, 32'h1, 32'h2000_0000, 4'hF, 1'b1},
      '{1'b0, 2'd2, 32'h2200_007C, 32'h0, 4'hF, 32'h1, 32'h2000_0000, 4'hF, 1'b1},
      '{1'b0, 2'd2, 32'h2200_0014, 32'h0, 4'hF, 32'h0, 32'h2000_0000, 4'hF, 1'b1},
      // set bit 5                                                   R5 R6
      '{1'b1, 2'd2, 32'h2200_0014, 32'h1, 4'hF, 32'h0, 32'h2000_0000, 4'hF, 1'b1},
      '{1'b0, 2'd2, 32'h2200_0014, 32'h0, 4'hF, 32'h1, 32'h2000_0000, 4'hF, 1'b1},
      // byte aliases into 0x40000011 (= 0xA5)                       R7
      '{1'b0, 2'd0, 32'h4200_0228, 32'h0, 4'hF, 32'h1, 32'h4000_0011, 4'h2, 1'b1},
      '{1'b0, 2'd0, 32'h4200_0224, 32'h0, 4'hF, 32'h0, 32'h4000_0011, 4'h2, 1'b1},
      // clear bit 7, upper data bits must be ignored                R6
      '{1'b1, 2'd0, 32'h4200_023C, 32'hFFFF_FFFE, 4'hF, 32'h0, 32'h4000_0011, 4'h2, 1'b1},
      // halfword aliases into 0x40000010 (= 0x2500)                 R3
      '{1'b0, 2'd1, 32'h4200_0234, 32'h0, 4'hF, 32'h1, 32'h4000_0010, 4'h3, 1'b1},
      '{1'b0, 2'd1, 32'h4200_023C, 32'h0, 4'hF, 32'h0, 32'h4000_0010, 4'h3, 1'b1},
      '{1'b0, 2'd1, 32'h4200_0220, 32'h0, 4'hF, 32'h1, 32'h4000_0010, 4'h3, 1'b1},
      '{1'b1, 2'd1, 32'h4200_0200, 32'h1, 4'hF, 32'h0, 32'h4000_0010, 4'h3, 1'b1},
      // pass-through                                                R9
      '{1'b0, 2'd2, 32'h2000_0000, 32'h0, 4'hF, 32'h8000_0021, 32'h2000_0000, 4'hF, 1'b0},
      '{1'b1, 2'd2, 32'h3000_0000, 32'hDEAD_BEEF, 4'hC, 32'h0, 32'h3000_0000, 4'hC, 1'b0},
      // upper halfword of 0x20000000                                R7
      '{1'b0, 2'd1, 32'h2200_007C, 32'h0, 4'hF, 32'h1, 32'h2000_0002, 4'hC, 1'b1},
      '{1'b0, 2'd1, 32'h2200_0078, 32'h0, 4'hF, 32'h0, 32'h2000_0002, 4'hC, 1'b1},
      '{1'b1, 2'd1, 32'h2200_0078, 32'h1, 4'hF, 32'h0, 32'h2000_0002, 4'hC, 1'b1},
      '{1'b0, 2'd2, 32'h2000_0000, 32'h0, 4'hF, 32'hC000_0021, 32'h2000_0000, 4'hF, 1'b0},
      '{1'b0, 2'd2, 32'h4000_0010, 32'h0, 4'hF, 32'h0000_2501, 32'h4000_0010, 4'hF, 1'b0},
      '{1'b0, 2'd2, 32'h3000_0000, 32'h0, 4'hF, 32'hDEAD_0000, 32'h3000_0000, 4'hF, 1'b0},
      // last alias word of the upper window                         R2
      '{1'b0, 2'd2, 32'h43FF_FFFC, 32'h0, 4'hF, 32'h0, 32'h400F_FFFC, 4'hF, 1'b1},
      '{1'b1, 2'd2, 32'h43FF_FFFC, 32'h3, 4'hF, 32'h0, 32'h400F_FFFC, 4'hF, 1'b1},
      '{1'b0, 2'd2, 32'h400F_FFFC, 32'h0, 4'hF, 32'h8000_0000, 32'h400F_FFFC, 4'hF, 1'b0},
      '{1'b0, 2'd2, 32'h43FF_FFFC, 32'h0, 4'hF, 32'h1, 32'h400F_FFFC, 4'hF, 1'b1},
      // just outside the windows                                    R2 R9
      '{1'b0, 2'd2, 32'h4400_0000, 32'h0, 4'hF, 32'h0, 32'h4400_0000, 4'hF, 1'b0},
      '{1'b0, 2'd2, 32'h21FF_FFFC, 32'h0, 4'hF, 32'h0, 32'h21FF_FFFC, 4'hF, 1'b0},
      '{1'b0, 2'd0, 32'h4000_0011, 32'h0, 4'h2, 32'h0000_2501, 32'h4000_0011, 4'h2, 1'b0}
   };

   task automatic run_vec(input vec_t v);
      logic [31:0] rd;
      int          ready_cycles;
      bit          got;
      @(negedge clk);
      log_n    = 0;
      up_valid = 1'b1;
      up_write = v.wr;
      up_size  = v.sz;
      up_addr  = v.addr;
      up_wdata = v.wdata;
      up_be    = v.be;
      got = 1'b0;
      rd  = '0;
      for (int t = 0; t < 100 && !got; t++) begin
         @(negedge clk);
         if (up_ready) begin
            got = 1'b1;
            rd  = up_rdata;
            if (v.is_alias && v.wr)
               chk(log_n == 2 && log_wr[1], "R8 ready before locked write acked", 32'(log_n), 32'd2);
         end
      end
      chk(got, "R10 request never completed", 32'(got), 32'd1);
      @(posedge clk);
      @(negedge clk);
      up_valid = 1'b0;
      chk(!up_ready, "R10 ready longer than one cycle", 32'(up_ready), 32'd0);
      if (!v.wr) begin
         if (v.is_alias)
            chk(rd == v.exp_rd, "R4 alias read result", rd, v.exp_rd);
         else
            chk(rd == v.exp_rd, "R9 forwarded read data", rd, v.exp_rd);
      end
      chk(log_n >= 1 && log_addr[0] == v.exp_maddr, "R2 memory address", log_addr[0], v.exp_maddr);
      chk(log_size[0] == v.sz, "R3 memory size", 32'(log_size[0]), 32'(v.sz));
      chk(log_be[0] == v.exp_mbe, "R7 byte enables", 32'(log_be[0]), 32'(v.exp_mbe));
      if (v.is_alias && v.wr) begin
         chk(log_n == 2 && !log_wr[0] && log_wr[1], "R5 read then write", 32'(log_n), 32'd2);
         chk(log_addr[1] == log_addr[0] && log_size[1] == log_size[0],
             "R5 write-back address", log_addr[1], log_addr[0]);
         chk(log_lock[0] && log_lock[1], "R8 lock over both phases",
             32'({log_lock[0], log_lock[1]}), 32'd3);
      end else begin
         chk(log_n == 1 && log_wr[0] == v.wr && !log_lock[0], "R9 single unlocked access",
             32'(log_n), 32'd1);
         if (!v.is_alias && v.wr)
            chk(log_wd[0] == v.wdata, "R9 forwarded write data", log_wd[0], v.wdata);
      end
   endtask

   initial begin
      words[32'h2000_0000 >> 2] = 32'h8000_0001;
      words[32'h4000_0010 >> 2] = 32'h0000_A500;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!mem_req && !mem_lock && !up_ready, "R1 outputs during reset",
          32'({mem_req, mem_lock, up_ready}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_req && !mem_lock && !up_ready, "R1 outputs after reset",
          32'({mem_req, mem_lock, up_ready}), 32'd0);
      repeat (4) @(negedge clk);
      chk(log_n == 0, "R1 no memory access while idle", 32'(log_n), 32'd0);

      for (int i = 0; i < NV; i++) run_vec(TBL[i]);

      // R6: neighbours preserved by the alias writes
      chk(peek(32'h2000_0000) == 32'hC000_0021, "R6 word 0x20000000", peek(32'h2000_0000), 32'hC000_0021);
      chk(peek(32'h4000_0010) == 32'h0000_2501, "R6 word 0x40000010", peek(32'h4000_0010), 32'h0000_2501);
      chk(peek(32'h400F_FFFC) == 32'h8000_0000, "R6 word 0x400FFFFC", peek(32'h400F_FFFC), 32'h8000_0000);

      // R1: reset in the middle of a locked write returns to idle
      @(negedge clk);
      up_valid = 1'b1; up_write = 1'b1; up_size = 2'd2;
      up_addr  = 32'h2200_0004; up_wdata = 32'h1; up_be = 4'hF;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0; up_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_req && !mem_lock && !up_ready, "R1 idle after mid-operation reset",
          32'({mem_req, mem_lock, up_ready}), 32'd0);

      finish_run();
   end
endmodule